// File: doc/BRIEF.md
# Ready-Latency Bridge

This block joins two streaming interfaces whose backpressure rules differ in timing. On one side, the ready signal applies in the same cycle as valid (ready latency 0). On the other side, a high ready in cycle n grants the right to send a beat in cycle n+LAT. The parameter `UP_ZERO` chooses which side is which, and `LAT` sets the nonzero latency.

Data, start-of-packet and end-of-packet markers pass through a small circular buffer. Their values and order are never changed. The ready signal sent upstream is computed from the free space in the buffer, counting beats that are already promised by earlier ready grants. Every output toward the downstream sink is driven from a register.

Top module: `ready_latency_bridge`

## Requirements
- R1: Every accepted beat leaves the block exactly once, in acceptance order, with its data, start marker and end marker unchanged.
- R2: With `UP_ZERO`=1 (upstream latency 0), a beat is taken only at a rising edge where `in_valid` and `in_ready` are both high. A beat held across cycles with `in_ready` low is taken once.
- R3: With `UP_ZERO`=0 (upstream latency `LAT`), every cycle with `in_valid` high delivers a beat. The source raises `in_valid` in cycle t only if `in_ready` was high in cycle t-`LAT`.
- R4: `in_ready` is high only when the buffer can take every beat already granted plus one more. No beat is lost however long the downstream side stalls.
- R5: With downstream latency 0 (`UP_ZERO`=0), if `out_valid` is high and `out_ready` is low, the next cycle presents the same beat with `out_valid` still high.
- R6: With downstream latency `LAT` (`UP_ZERO`=1), `out_valid` is high in cycle t only if `out_ready` was high in cycle t-`LAT`. Every such beat counts as consumed.
- R7: While `rst` is high, `in_ready` and `out_valid` are low. Beats held at reset are discarded and never appear afterwards.
- R8: With the source always sending and the sink always ready, the block delivers one beat per cycle in steady state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream beat present |
| in_data | input | DATA_W | Upstream beat payload |
| in_sop | input | 1 | Upstream beat opens a packet |
| in_eop | input | 1 | Upstream beat closes a packet |
| in_ready | output | 1 | Registered grant to the upstream source |
| out_valid | output | 1 | Registered downstream beat present |
| out_data | output | DATA_W | Registered downstream payload |
| out_sop | output | 1 | Registered start-of-packet marker |
| out_eop | output | 1 | Registered end-of-packet marker |
| out_ready | input | 1 | Downstream sink ready |

## Verification
The hardest situation to reach is a full buffer with several grants still outstanding. In that state `in_ready` must already have dropped `LAT` cycles before the last granted beat arrives. The bench reaches it by sweeping source and sink activity patterns against each other, including long sink stalls with a source that fires on every permitted cycle. A mid-stream reset with a full buffer then shows that held beats are discarded.

// File: rtl/ready_latency_bridge.sv
module ready_latency_bridge #(
  parameter int DATA_W  = 16,
  parameter int LAT     = 2,
  parameter bit UP_ZERO = 1'b1,
  parameter int DEPTH   = LAT + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  input  logic              out_ready
);
  localparam int LU = UP_ZERO ? 0 : LAT;
  localparam int LD = UP_ZERO ? LAT : 0;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int W  = DATA_W + 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          up_slot, pull, wr, rd, ready_next;
  int            pend, cnt_next;

  generate
    if (LU == 0) begin : g_up0
      assign up_slot = in_ready;
      assign pend    = 0;
    end else begin : g_upn
      logic [LU:1] upipe;
      always_ff @(posedge clk) begin
        if (rst) upipe <= '0;
        else begin
          upipe[1] <= in_ready;
          for (int k = 2; k <= LU; k++) upipe[k] <= upipe[k-1];
        end
      end
      assign up_slot = upipe[LU];
      assign pend    = $countones(upipe) - int'(upipe[LU]) + int'(in_ready);
      AST_UP_SLOT: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> upipe[LU]); // R3
    end

    if (LD == 0) begin : g_dn0
      assign pull = !out_valid || out_ready;
      AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
          && $stable(out_sop) && $stable(out_eop)); // R5
    end else begin : g_dnn
      logic [LD:1] dpipe;
      always_ff @(posedge clk) begin
        if (rst) dpipe <= '0;
        else begin
          dpipe[1] <= out_ready;
          for (int k = 2; k <= LD; k++) dpipe[k] <= dpipe[k-1];
        end
      end
      if (LD == 1) begin : g_l1
        assign pull = out_ready;
      end else begin : g_ln
        assign pull = dpipe[LD-1];
      end
      AST_DN_SLOT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> dpipe[LD]); // R6
    end
  endgenerate

  assign wr = in_valid && up_slot;
  assign rd = pull && (count != '0);

  always_comb begin
    cnt_next   = int'(count) + (wr ? 1 : 0) - (rd ? 1 : 0);
    ready_next = (cnt_next + pend + 1) <= DEPTH;
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= {in_sop, in_eop, in_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      in_ready <= ready_next;
      count    <= CW'(cnt_next);
      if (wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (pull) begin
        out_valid <= rd;
        if (rd) {out_sop, out_eop, out_data} <= mem[rptr];
      end else if (LD > 0) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr |-> int'(count) < DEPTH); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid && !$past(out_valid) |-> $past(count) != '0); // R1
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid && !in_ready && count == '0); // R7
endmodule

// File: tb/sim_ready_latency_bridge.sv
module sim_ready_latency_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int LA = 3;
  localparam int LB = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic a_iv = 0, a_is = 0, a_ie = 0, a_ir, a_ov, a_os, a_oe, a_or = 0;
  logic [DW-1:0] a_id = '0, a_od;
  logic b_iv = 0, b_is = 0, b_ie = 0, b_ir, b_ov, b_os, b_oe, b_or = 0;
  logic [DW-1:0] b_id = '0, b_od;

  ready_latency_bridge #(.DATA_W(DW), .LAT(LA), .UP_ZERO(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(a_iv), .in_data(a_id), .in_sop(a_is),
    .in_eop(a_ie), .in_ready(a_ir), .out_valid(a_ov), .out_data(a_od),
    .out_sop(a_os), .out_eop(a_oe), .out_ready(a_or));

  ready_latency_bridge #(.DATA_W(DW), .LAT(LB), .UP_ZERO(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(b_iv), .in_data(b_id), .in_sop(b_is),
    .in_eop(b_ie), .in_ready(b_ir), .out_valid(b_ov), .out_data(b_od),
    .out_sop(b_os), .out_eop(b_oe), .out_ready(b_or));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int a_sent = 0, a_rcv = 0, b_sent = 0, b_rcv = 0;
  bit a_pend = 0, b_stall = 0;
  bit ah [64];
  bit bh [64];
  logic [DW+1:0] b_hold = '0;

  function automatic logic [DW-1:0] edat(int k);
    return DW'(k * 37 + 5);
  endfunction
  function automatic bit esop(int k);
    int o = k % 10;
    return o == 0 || o == 1 || o == 3 || o == 6;
  endfunction
  function automatic bit eeop(int k);
    int o = k % 10;
    return o == 0 || o == 2 || o == 5 || o == 9;
  endfunction
  function automatic bit gate(int mode, int c, int salt);
    case (mode)
      0: return 1'b1;
      1: return ((c * 13 + salt) % 7) < 4;
      2: return (c % 3) != 0;
      default: return ((c + salt) % 5) == 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int sa, input int ka, input int sb, input int kb, input bit srcon);
    @(negedge clk);
    cyc++;
    // u0 upstream, latency 0 (R2)
    if (a_pend) a_sent++;
    if (!(a_iv && !a_pend)) begin
      a_iv = srcon && gate(sa, cyc, 1);
      a_id = edat(a_sent); a_is = esop(a_sent); a_ie = eeop(a_sent);
    end
    a_pend = a_iv && a_ir;
    // u0 downstream, latency LA (R6)
    a_or = gate(ka, cyc, 2);
    ah[cyc % 64] = a_or;
    if (a_ov) begin
      chk(ah[(cyc - LA + 64) % 64], "R6 out_valid outside ready cycle", 1, 0);
      chk(a_od == edat(a_rcv), "R1 R2 u0 data", int'(a_od), int'(edat(a_rcv)));
      chk({a_os, a_oe} == {esop(a_rcv), eeop(a_rcv)}, "R1 u0 markers",
          int'({a_os, a_oe}), int'({esop(a_rcv), eeop(a_rcv)}));
      a_rcv++;
    end
    // u1 upstream, latency LB (R3)
    bh[cyc % 64] = b_ir;
    b_iv = srcon && bh[(cyc - LB + 64) % 64] && gate(sb, cyc, 3);
    if (b_iv) begin
      b_id = edat(b_sent); b_is = esop(b_sent); b_ie = eeop(b_sent);
      b_sent++;
    end
    // u1 downstream, latency 0 (R5)
    if (b_stall)
      chk(b_ov && {b_os, b_oe, b_od} == b_hold, "R5 stalled beat changed",
          int'({b_ov, b_os, b_oe, b_od}), int'({1'b1, b_hold}));
    b_or = gate(kb, cyc, 4);
    if (b_ov && b_or) begin
      chk(b_od == edat(b_rcv), "R1 R3 u1 data", int'(b_od), int'(edat(b_rcv)));
      chk({b_os, b_oe} == {esop(b_rcv), eeop(b_rcv)}, "R1 u1 markers",
          int'({b_os, b_oe}), int'({esop(b_rcv), eeop(b_rcv)}));
      b_rcv++;
    end
    b_stall = b_ov && !b_or;
    b_hold  = {b_os, b_oe, b_od};
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a0, b0;
    repeat (3) @(negedge clk);
    chk(!a_ir && !a_ov && !b_ir && !b_ov, "R7 reset state", int'({a_ir, a_ov, b_ir, b_ov}), 0);
    rst = 1'b0;
    for (int p = 0; p < 16; p++)
      for (int i = 0; i < 150; i++) step(p % 4, p / 4, (p + 1) % 4, (15 - p) / 4, 1'b1);
    // long sink stall with eager sources (R4)
    for (int i = 0; i < 40; i++) step(0, 3, 0, 3, 1'b1);
    repeat (20) step(0, 0, 0, 0, 1'b1);
    a0 = a_rcv; b0 = b_rcv;
    repeat (60) step(0, 0, 0, 0, 1'b1);
    chk(a_rcv - a0 == 60, "R8 u0 throughput", a_rcv - a0, 60);
    chk(b_rcv - b0 == 60, "R8 u1 throughput", b_rcv - b0, 60);
    repeat (40) step(0, 0, 0, 0, 1'b0);
    if (a_pend) a_sent++;
    a_pend = 0;
    chk(a_rcv == a_sent, "R4 u0 no beat lost", a_rcv, a_sent);
    chk(b_rcv == b_sent, "R4 u1 no beat lost", b_rcv, b_sent);
    chk(a_sent > 500 && b_sent > 500, "R1 stream volume", a_sent < b_sent ? a_sent : b_sent, 500);
    // fill buffers, then reset mid-stream (R7)
    repeat (30) step(0, 3, 0, 3, 1'b1);
    @(negedge clk);
    rst = 1'b1; a_iv = 0; b_iv = 0; a_or = 0; b_or = 0; a_pend = 0; b_stall = 0;
    @(negedge clk);
    @(negedge clk);
    chk(!a_ir && !a_ov && !b_ir && !b_ov, "R7 in reset", int'({a_ir, a_ov, b_ir, b_ov}), 0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      a_or = 1'b1; b_or = 1'b1;
      chk(!a_ov && !b_ov, "R7 discarded beat reappeared", int'({a_ov, b_ov}), 0);
    end
    chk(a_ir && b_ir, "R7 ready after reset", int'({a_ir, b_ir}), 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule